// File: doc/BRIEF.md
# Countdown Timer with Read-to-Clear Interrupt

This block is a single-channel down-counting timer that sits on a simple register bus with one combined read/write port. Software writes a start value, then sets the run bit in the control register. The counter takes that start value on the cycle that the run bit goes from clear to set. From then on it steps down by one every clock. When the count is zero, the next step sets a pending interrupt flag. The counter then either reloads the start value (periodic mode) or wraps to all ones (free-running mode).

The pending flag drives the interrupt output unless the mask bit hides it. Software acknowledges the interrupt by reading a dedicated acknowledge register, and that read clears the flag. If the count reaches zero again in the same cycle as the acknowledge read, the flag stays set, so no event is lost. A start value written while the timer runs has no effect on the live count until the next run edge or the next periodic reload.

Top module: `cdt_timer`

## Requirements
- R1: A synchronous reset clears the start value, the control bits, the count and the pending flag, so every register reads zero and the interrupt output is low.
- R2: Register words are selected by byte address. 0x00 holds the start value (read/write). 0x04 returns the live count. 0x08 is control: bit 0 run, bit 1 mode (1 = periodic, 0 = free-running), bit 2 mask. 0x0C is the acknowledge register. 0x10 is status, with the visible interrupt in bit 0. Any other address reads zero.
- R3: The start value reads back what was last written. The counter copies it only on a control write that moves the run bit from 0 to 1. A write while the timer runs leaves the live count undisturbed.
- R4: While run is set, the count decreases by one on every clock.
- R5: In periodic mode, the step taken while the count is zero reloads the current start value and sets the pending flag. A start value L therefore gives an interrupt every L+1 clocks.
- R6: In free-running mode, the step taken while the count is zero wraps the count to all ones and sets the pending flag.
- R7: While run is clear, the count holds its value and the pending flag is not set.
- R8: Status bit 0 and the interrupt output are both equal to pending AND NOT mask. The mask bit does not stop the flag from being recorded.
- R9: Reading the acknowledge register returns zero and clears the pending flag. Reading status does not clear it.
- R10: If an acknowledge read and a zero-count step fall in the same cycle, the pending flag remains set.
- R11: Writes to the live count, acknowledge and status addresses change no state.
- R12: Writing zero to control stops the counter, selects free-running mode and unmasks the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the request |
| irq | output | 1 | Interrupt, pending and not masked |

## Verification
The case that is hardest to reach is an acknowledge read landing in the exact cycle in which the count sits at zero and the flag is set again. The stimulus gets there by running a short periodic count with back-to-back bus accesses, each of which takes one clock. The number of accesses before the acknowledge read is chosen so that this read lines up with the zero step. A following status read then has to show the flag still set. The same counted sequence also puts a start-value write in the middle of a running period, and it checks that the write takes effect only at the next reload.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    // Word indexes (byte address / 4) of the register map
    localparam int IDX_START  = 0;
    localparam int IDX_COUNT  = 1;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_ACK    = 3;
    localparam int IDX_STATUS = 4;

    // Control bit positions
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_MASK_BIT = 2;
    localparam int CTRL_W        = 3;

    typedef struct packed {
        logic mask;
        logic periodic;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] start_val_o,
    output ctrl_t             ctrl_o,
    output logic              run_edge_o,
    output logic              ack_rd_o
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] start_val;
        ctrl_t             ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             sel_start, sel_count, sel_ctrl, sel_ack, sel_status;
    logic             wr_start, wr_ctrl;
    ctrl_t            ctrl_wr;

    always_comb begin
        idx        = addr_i[ADDR_W-1:2];
        aligned    = (addr_i[1:0] == 2'b00);
        sel_start  = aligned && (idx == IDX_W'(IDX_START));
        sel_count  = aligned && (idx == IDX_W'(IDX_COUNT));
        sel_ctrl   = aligned && (idx == IDX_W'(IDX_CTRL));
        sel_ack    = aligned && (idx == IDX_W'(IDX_ACK));
        sel_status = aligned && (idx == IDX_W'(IDX_STATUS));

        wr_start = req_i && wr_i && sel_start;
        wr_ctrl  = req_i && wr_i && sel_ctrl;

        ctrl_wr.run      = wdata_i[CTRL_RUN_BIT];
        ctrl_wr.periodic = wdata_i[CTRL_MODE_BIT];
        ctrl_wr.mask     = wdata_i[CTRL_MASK_BIT];

        regs_d = regs_q;
        if (wr_start) begin
            regs_d.start_val = wdata_i;
        end
        if (wr_ctrl) begin
            regs_d.ctrl = ctrl_wr;
        end

        // The counter copies the start value only on a 0 -> 1 run transition
        run_edge_o = wr_ctrl && ctrl_wr.run && !regs_q.ctrl.run;
        ack_rd_o   = req_i && !wr_i && sel_ack;

        rdata_o = '0;
        if (sel_start) begin
            rdata_o = regs_q.start_val;
        end else if (sel_count) begin
            rdata_o = count_i;
        end else if (sel_ctrl) begin
            rdata_o = DATA_W'(regs_q.ctrl);
        end else if (sel_status) begin
            rdata_o = DATA_W'(status_i);
        end

        start_val_o = regs_q.start_val;
        ctrl_o      = regs_q.ctrl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R12: a zero written to control leaves every control bit clear
    a_r12_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata_i == '0) |=> (regs_q.ctrl == '0));

    // R11: writes to the read-only addresses leave the stored registers untouched
    a_r11_ro_write: assert property (@(posedge clk) disable iff (rst)
        (req_i && wr_i && (sel_count || sel_ack || sel_status)) |=> $stable(regs_q));

    // R3: the start value reads back the last value written
    a_r3_readback: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> (start_val_o == $past(wdata_i)));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              run_edge_i,
    input  logic              periodic_i,
    input  logic [DATA_W-1:0] start_val_i,
    output logic [DATA_W-1:0] count_o,
    output logic              zero_step_o
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d       = cnt_q;
        zero_step_o = run_i && !run_edge_i && (cnt_q.count == '0);
        if (run_edge_i) begin
            cnt_d.count = start_val_i;
        end else if (zero_step_o) begin
            cnt_d.count = periodic_i ? start_val_i : '1;
        end else if (run_i) begin
            cnt_d.count = cnt_q.count - 1'b1;
        end
        count_o = cnt_q.count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: the count is frozen while stopped
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !run_edge_i) |=> $stable(count_o));

    // R3: a run edge copies the start value
    a_r3_take: assert property (@(posedge clk) disable iff (rst)
        run_edge_i |=> (count_o == $past(start_val_i)));

    // R4: one step down per clock while running above zero
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (run_i && !run_edge_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

    // R6: free-running wrap to all ones
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (zero_step_o && !periodic_i) |=> (&count_o));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst,
    input  logic zero_step_i,
    input  logic ack_rd_i,
    input  logic mask_i,
    output logic status_o,
    output logic irq_o
);
    typedef struct packed {
        logic pending;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A new zero step takes priority over an acknowledge in the same cycle
        if (zero_step_i) begin
            st_d.pending = 1'b1;
        end else if (ack_rd_i) begin
            st_d.pending = 1'b0;
        end
        status_o = st_q.pending && !mask_i;
        irq_o    = status_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a zero step always leaves the flag set
    a_r10_keep: assert property (@(posedge clk) disable iff (rst)
        zero_step_i |=> st_q.pending);

    // R9: an acknowledge with no competing zero step clears the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (ack_rd_i && !zero_step_i) |=> !st_q.pending);

    // R7: no zero step means no newly raised flag
    a_r7_no_raise: assert property (@(posedge clk) disable iff (rst)
        (!st_q.pending && !zero_step_i) |=> !st_q.pending);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] start_val;
    logic [DATA_W-1:0] count;
    ctrl_t             ctrl;
    logic              run_edge;
    logic              ack_rd;
    logic              zero_step;
    logic              status;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (bus_req),
        .wr_i        (bus_wr),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .count_i     (count),
        .status_i    (status),
        .rdata_o     (bus_rdata),
        .start_val_o (start_val),
        .ctrl_o      (ctrl),
        .run_edge_o  (run_edge),
        .ack_rd_o    (ack_rd)
    );

    cdt_counter #(.DATA_W(DATA_W)) counter_i (
        .clk         (clk),
        .rst         (rst),
        .run_i       (ctrl.run),
        .run_edge_i  (run_edge),
        .periodic_i  (ctrl.periodic),
        .start_val_i (start_val),
        .count_o     (count),
        .zero_step_o (zero_step)
    );

    cdt_irq irq_i (
        .clk         (clk),
        .rst         (rst),
        .zero_step_i (zero_step),
        .ack_rd_i    (ack_rd),
        .mask_i      (ctrl.mask),
        .status_o    (status),
        .irq_o       (irq)
    );

    // R8: a masked interrupt never reaches the output
    a_r8_masked: assert property (@(posedge clk) disable iff (rst)
        ctrl.mask |-> !irq);

    // R5: a periodic zero step reloads the start value
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (zero_step && ctrl.periodic) |=> (count == $past(start_val)));
endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_START  = 5'h00;
    localparam logic [ADDR_W-1:0] A_COUNT  = 5'h04;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] A_ACK    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h10;
    localparam logic [ADDR_W-1:0] A_NONE   = 5'h14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    cdt_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic void check(input string tag, input logic [DATA_W-1:0] act,
                                  input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // Monitor: samples read data 3 ns after the driving edge, 2 ns before the clock rises
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (bus_req && !bus_wr) begin
                if (sb_q.size() == 0) begin
                    check("SCOREBOARD", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                      input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_req = 1'b0; bus_wr = 1'b0;
        end
    endtask

    // Checks the irq pin in the cycle that was just driven
    task automatic chk_irq(input logic e, input string tag);
        #3;
        check(tag, DATA_W'(irq), DATA_W'(e));
    endtask

    initial begin
        #2_000_000;
        check("WATCHDOG", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(A_START, 0, "R1"); chk_irq(1'b0, "R1");
        rd(A_COUNT, 0, "R1");
        rd(A_CTRL, 0, "R1");
        rd(A_STATUS, 0, "R1");
        rd(A_NONE, 0, "R2");

        // Periodic run, start value 5
        wr(A_START, 5);
        wr(A_CTRL, 3);
        rd(A_CTRL, 3, "R2");       // count 5 -> 4
        rd(A_COUNT, 4, "R4");
        rd(A_COUNT, 3, "R4");
        rd(A_COUNT, 2, "R4");
        rd(A_COUNT, 1, "R4");
        rd(A_COUNT, 0, "R4"); chk_irq(1'b0, "R8");   // zero step at this edge
        rd(A_STATUS, 1, "R5"); chk_irq(1'b1, "R8");  // count 5 -> 4
        wr(A_START, 9);                              // 4 -> 3
        rd(A_COUNT, 3, "R3");                        // 3 -> 2
        rd(A_START, 9, "R3");                        // 2 -> 1
        rd(A_STATUS, 1, "R9");                       // 1 -> 0, status read does not clear
        rd(A_ACK, 0, "R9");                          // zero step coincides with ack
        rd(A_STATUS, 1, "R10");                      // reloaded 9 -> 8
        rd(A_ACK, 0, "R9");                          // 8 -> 7, flag cleared
        rd(A_STATUS, 0, "R9"); chk_irq(1'b0, "R9");  // 7 -> 6
        rd(A_COUNT, 6, "R5");                        // 6 -> 5

        // Masking
        wr(A_CTRL, 7);                               // 5 -> 4
        idle(5);                                     // 4..0, zero step on last
        rd(A_STATUS, 0, "R8"); chk_irq(1'b0, "R8");  // 9 -> 8
        wr(A_CTRL, 3);                               // 8 -> 7
        rd(A_STATUS, 1, "R8"); chk_irq(1'b1, "R8");  // 7 -> 6

        // Writes to read-only addresses
        wr(A_COUNT, 32'h55);                         // 6 -> 5
        wr(A_STATUS, 0);                             // 5 -> 4
        wr(A_ACK, 0);                                // 4 -> 3
        rd(A_COUNT, 3, "R11");                       // 3 -> 2
        rd(A_STATUS, 1, "R11");                      // 2 -> 1

        // Stop
        wr(A_CTRL, 2);                               // 1 -> 0, then stopped
        rd(A_COUNT, 0, "R7");
        rd(A_ACK, 0, "R9");
        idle(3);
        rd(A_STATUS, 0, "R7");
        rd(A_COUNT, 0, "R7");

        // Run edge takes the new start value
        wr(A_START, 2);
        wr(A_CTRL, 3);                               // count = 2
        rd(A_COUNT, 2, "R3");
        rd(A_COUNT, 1, "R4");
        rd(A_COUNT, 0, "R4");
        rd(A_COUNT, 2, "R5");                        // 2 -> 1
        wr(A_CTRL, 0);                               // 1 -> 0, then stopped
        rd(A_CTRL, 0, "R12");
        rd(A_COUNT, 0, "R12");
        rd(A_ACK, 0, "R9");

        // Free-running
        wr(A_START, 1);
        wr(A_CTRL, 1);                               // count = 1
        rd(A_COUNT, 1, "R4");
        rd(A_COUNT, 0, "R6");                        // wrap at this edge
        rd(A_COUNT, 32'hFFFF_FFFF, "R6");
        rd(A_STATUS, 1, "R6"); chk_irq(1'b1, "R6");  // FE -> FD
        rd(A_COUNT, 32'hFFFF_FFFD, "R6");            // FD -> FC
        wr(A_CTRL, 5);                               // FC -> FB
        rd(A_STATUS, 0, "R8");                       // FB -> FA
        wr(A_CTRL, 0);                               // FA -> F9, stop
        rd(A_STATUS, 1, "R12"); chk_irq(1'b1, "R12");
        rd(A_COUNT, 32'hFFFF_FFF9, "R12");
        rd(A_COUNT, 32'hFFFF_FFF9, "R7");

        // Reset while running
        wr(A_START, 7);
        wr(A_CTRL, 3);
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(A_COUNT, 0, "R1");
        rd(A_START, 0, "R1");
        rd(A_CTRL, 0, "R1");
        idle(3);
        if (sb_q.size() != 0) check("SCOREBOARD", 32'(sb_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule